// File: doc/BRIEF.md
# Multi-Domain Reset Release Controller

This block takes one active-low asynchronous reset from the chip and turns it into a separate local reset for each of several unrelated clock domains. Some of the domains are sources and one is a consumer. Each local reset takes effect the moment the chip reset goes low, even when no clock is running. Each local reset is released only on an edge of that domain's own clock, after a parameterised number of stages. Every domain has its own release chain, so no released reset ever crosses into a foreign clock domain.

Each source domain raises a ready flag one local clock after its reset lets go. The flags cross into the consumer domain through two-flop synchronizers. The consumer's combined ready output rises only when every synchronized source flag and the consumer's own flag are high on the same consumer edge. This keeps the consumer from starting while one of its inputs is still at its reset value.

During scan test the incoming reset is masked, so tester glitches cannot disturb the flops. While a domain's local reset is active, its clock-gate enable is forced on, so a gated-off clock cannot stall the reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: When `arst_n_i` goes low with `scan_mode_i` low, every bit of `rst_n_o` goes low, `src_ready_o` and `all_ready_o` go low, and none of this needs a clock edge.
- R2: After `arst_n_i` rises, `rst_n_o[g]` rises on the DEPTH-th rising edge of `clk_i[g]` (DEPTH raised to 2 if set lower) and on no other clock.
- R3: Each domain releases on its own: a domain whose clock is stopped stays in reset while the others release, and it releases once its clock runs again.
- R4: `src_ready_o[s]` (bit s is source domain s, which is clocked by `clk_i[s]`) rises on the first `clk_i[s]` edge after `rst_n_o[s]` has risen.
- R5: `all_ready_o` is never high while any `src_ready_o` bit is low or while the consumer domain (index NUM_SRC of `clk_i`/`rst_n_o`) is in reset. It rises only after every source flag has passed through the consumer's synchronizers.
- R6: `cg_en_o[g]` is 1 while `rst_n_o[g]` is low, whatever `func_en_i[g]` is, and it equals `func_en_i[g]` once the domain is out of reset.
- R7: While `scan_mode_i` is 1, a low level on `arst_n_i` has no effect: `rst_n_o`, `src_ready_o` and `all_ready_o` keep their values.
- R8: Domain indexing: bits 0 to NUM_SRC-1 of `clk_i`, `func_en_i`, `rst_n_o` and `cg_en_o` are the source domains, and bit NUM_SRC is the consumer domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n_i | input | 1 | Chip-level asynchronous reset, active low |
| scan_mode_i | input | 1 | Scan test mode; masks `arst_n_i` while 1 |
| clk_i | input | NUM_SRC+1 | One clock per domain; the top bit is the consumer clock |
| func_en_i | input | NUM_SRC+1 | Functional clock-gate enable per domain |
| rst_n_o | output | NUM_SRC+1 | Local reset per domain, active low |
| cg_en_o | output | NUM_SRC+1 | Effective clock-gate enable per domain |
| src_ready_o | output | NUM_SRC | Ready flag per source domain, in its own clock domain |
| all_ready_o | output | 1 | Consumer-domain flag: all sources and the consumer are ready |

## Verification
The hardest case to reach from the ports is one where the domains are out of step: one domain is held with its clock stopped while the others release and raise their flags, and the consumer must still hold back. The bench reaches this by gating each clock with a per-domain run mask. It stops chosen source clocks, or the consumer clock, before releasing the reset at varied offsets from the unrelated clock phases. It then checks the per-domain edge counts, the held domain and the combined ready output. It also stops every clock before asserting the reset, to show that assertion needs no edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int unsigned MIN_STAGES  = 2;
    localparam int unsigned SYNC_STAGES = 2;

    // Depth actually built: a request below the minimum is raised to it.
    function automatic int unsigned stage_count(input int unsigned req);
        return (req < MIN_STAGES) ? MIN_STAGES : req;
    endfunction

    // Per-domain state handed from a domain to the top.
    typedef struct packed {
        logic rst_n;   // local reset, active low
        logic ready;   // domain has been out of reset for one clock
    } dom_state_t;

endpackage

// File: rtl/rst_domain.sv
module rst_domain
    import rstseq_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic       clk_i,
    input  logic       arst_n_i,
    input  logic       func_en_i,
    output dom_state_t state_o,
    output logic       cg_en_o
);

    logic [STAGES-1:0] chain_q;
    logic              ready_q;

    // Release chain: cleared at once by the chip reset; ones shift in on the local clock.
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    // Ready flag: cleared by the local reset, set one local clock after release.
    always_ff @(posedge clk_i or negedge chain_q[STAGES-1]) begin
        if (!chain_q[STAGES-1]) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign state_o.rst_n = chain_q[STAGES-1];
    assign state_o.ready = ready_q;

    // The clock must run while the reset is active, so reset forces the enable on.
    assign cg_en_o = func_en_i | ~chain_q[STAGES-1];

endmodule

// File: rtl/flag_sync.sv
module flag_sync
    import rstseq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic flag_i,
    output logic flag_o
);

    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], flag_i};
        end
    end

    assign flag_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ready_gate.sv
module ready_gate #(
    parameter int unsigned NUM_SRC = 3
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               local_ready_i,
    input  logic [NUM_SRC-1:0] src_ready_i,
    output logic               all_ready_o
);

    logic [NUM_SRC-1:0] seen;
    logic               all_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
        flag_sync u_sync (
            .clk_i  (clk_i),
            .rst_n_i(rst_n_i),
            .flag_i (src_ready_i[s]),
            .flag_o (seen[s])
        );
    end

    // Rises only when every synchronized flag is high on the same consumer edge.
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            all_q <= 1'b0;
        end else begin
            all_q <= local_ready_i & (&seen);
        end
    end

    assign all_ready_o = all_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned DEPTH   = 3
) (
    input  logic               arst_n_i,
    input  logic               scan_mode_i,
    input  logic [NUM_SRC:0]   clk_i,
    input  logic [NUM_SRC:0]   func_en_i,
    output logic [NUM_SRC:0]   rst_n_o,
    output logic [NUM_SRC:0]   cg_en_o,
    output logic [NUM_SRC-1:0] src_ready_o,
    output logic               all_ready_o
);

    localparam int unsigned NUM_DOM = NUM_SRC + 1;
    localparam int unsigned CONS    = NUM_SRC;
    localparam int unsigned STAGES  = stage_count(DEPTH);

    // Scan mode holds the incoming reset inactive; one reset source only.
    logic       arst_masked_n;
    dom_state_t dstate [NUM_DOM];

    assign arst_masked_n = arst_n_i | scan_mode_i;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        rst_domain #(.STAGES(STAGES)) u_dom (
            .clk_i    (clk_i[g]),
            .arst_n_i (arst_masked_n),
            .func_en_i(func_en_i[g]),
            .state_o  (dstate[g]),
            .cg_en_o  (cg_en_o[g])
        );
        assign rst_n_o[g] = dstate[g].rst_n;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_ready_o[s] = dstate[s].ready;
    end

    ready_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .clk_i        (clk_i[CONS]),
        .rst_n_i      (dstate[CONS].rst_n),
        .local_ready_i(dstate[CONS].ready),
        .src_ready_i  (src_ready_o),
        .all_ready_o  (all_ready_o)
    );

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned DEPTH   = 3
) (
    input logic               arst_n_i,
    input logic               scan_mode_i,
    input logic [NUM_SRC:0]   clk_i,
    input logic [NUM_SRC:0]   rst_n_o,
    input logic [NUM_SRC-1:0] src_ready_o,
    input logic               all_ready_o
);

    for (genvar g = 0; g <= NUM_SRC; g++) begin : g_dom_chk
        // R1: a low chip reset outside scan mode means the local reset is active
        a_r1_async_assert: assert property (@(posedge clk_i[g]) disable iff (scan_mode_i)
            !arst_n_i |-> !rst_n_o[g]);

        // R2: a local release follows a clock on which the chip reset was already inactive
        a_r2_release_after_input: assert property (@(posedge clk_i[g])
            disable iff (!(arst_n_i | scan_mode_i))
            $rose(rst_n_o[g]) |-> $past(arst_n_i | scan_mode_i));

        // R7: in scan mode a released domain stays released
        a_r7_scan_mask: assert property (@(posedge clk_i[g]) disable iff (!scan_mode_i)
            ($past(rst_n_o[g]) && $past(scan_mode_i)) |-> rst_n_o[g]);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
        // R4: a ready flag rises only after its domain's reset has already let go
        a_r4_ready_after_release: assert property (@(posedge clk_i[s]) disable iff (!rst_n_o[s])
            $rose(src_ready_o[s]) |-> $past(rst_n_o[s]));
    end

    // R5: combined ready implies every source ready
    a_r5_all_needs_sources: assert property (@(posedge clk_i[NUM_SRC])
        disable iff (!(arst_n_i | scan_mode_i))
        all_ready_o |-> (&src_ready_o));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_chk (
    .arst_n_i   (arst_n_i),
    .scan_mode_i(scan_mode_i),
    .clk_i      (clk_i),
    .rst_n_o    (rst_n_o),
    .src_ready_o(src_ready_o),
    .all_ready_o(all_ready_o)
);

// File: tb/tb_rst_seq_ctrl.sv
`timescale 1ns/100ps
module tb_rst_seq_ctrl;

    localparam int NSRC  = 3;
    localparam int NDOM  = NSRC + 1;
    localparam int DEPTH = 3;
    // Half periods in ns; the consumer (last) runs at 250 MHz.
    localparam int HALF [NDOM] = '{3, 5, 7, 2};

    // Vector table: release offset after a consumer falling edge, and mask of stopped clocks.
    localparam int NVEC = 7;
    localparam int DLY  [NVEC] = '{0, 1, 3, 5, 8, 13, 2};
    localparam int STOP [NVEC] = '{0, 0, 1, 0, 4, 8, 2};

    logic            arst_n    = 1'b0;
    logic            scan_mode = 1'b0;
    logic [NDOM-1:0] run       = '1;
    logic [NDOM-1:0] func_en   = '0;
    logic [NDOM-1:0] clk_i;
    logic [NDOM-1:0] rst_n_o;
    logic [NDOM-1:0] cg_en_o;
    logic [NSRC-1:0] src_ready_o;
    logic            all_ready_o;
    logic            mon_clk = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int rcnt [NDOM];
    int ycnt [NSRC];

    for (genvar g = 0; g < NDOM; g++) begin : g_clk
        logic r = 1'b0;
        initial forever #(HALF[g]) r = ~r;
        assign clk_i[g] = r & run[g];
    end
    initial forever #2 mon_clk = ~mon_clk;

    rst_seq_ctrl #(.NUM_SRC(NSRC), .DEPTH(DEPTH)) dut (
        .arst_n_i   (arst_n),
        .scan_mode_i(scan_mode),
        .clk_i      (clk_i),
        .func_en_i  (func_en),
        .rst_n_o    (rst_n_o),
        .cg_en_o    (cg_en_o),
        .src_ready_o(src_ready_o),
        .all_ready_o(all_ready_o)
    );

    // Edge counters: local edges spent in reset, and edges between release and ready.
    for (genvar g = 0; g < NDOM; g++) begin : g_cnt
        always @(posedge clk_i[g] or negedge arst_n) begin
            if (!arst_n) rcnt[g] <= 0;
            else if (!rst_n_o[g]) rcnt[g] <= rcnt[g] + 1;
        end
        if (g < NSRC) begin : g_y
            always @(posedge clk_i[g] or negedge arst_n) begin
                if (!arst_n) ycnt[g] <= 0;
                else if (rst_n_o[g] && !src_ready_o[g]) ycnt[g] <= ycnt[g] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // R5 monitor: combined ready must never lead any source flag.
    int mon_bad = 0;
    always @(negedge mon_clk) begin
        if (all_ready_o === 1'b1 && src_ready_o !== '1) mon_bad++;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        // Reset state
        #20.5;
        chk(rst_n_o == '0, "R1", "rst_n_o in reset", rst_n_o, 0);
        chk(src_ready_o == '0 && all_ready_o == 1'b0, "R1", "ready in reset",
            {src_ready_o, all_ready_o}, 0);
        chk(cg_en_o == '1, "R6", "cg_en forced in reset", cg_en_o, 4'hF);

        // Table of release offsets and stopped clocks
        for (int v = 0; v < NVEC; v++) begin
            arst_n = 1'b0;
            #30;
            run = ~STOP[v][NDOM-1:0];
            @(negedge mon_clk);
            #(DLY[v]);
            #0.5 arst_n = 1'b1;
            #300;
            for (int g = 0; g < NDOM; g++) begin
                if (STOP[v][g]) begin
                    chk(rst_n_o[g] == 1'b0, "R3", $sformatf("v%0d stopped dom %0d held", v, g),
                        rst_n_o[g], 0);
                end else begin
                    chk(rcnt[g] == DEPTH && rst_n_o[g], "R2",
                        $sformatf("v%0d dom %0d release edges", v, g), rcnt[g], DEPTH);
                    if (g < NSRC)
                        chk(ycnt[g] == 1 && src_ready_o[g], "R4",
                            $sformatf("v%0d src %0d ready edges", v, g), ycnt[g], 1);
                end
            end
            chk(all_ready_o == (STOP[v] == 0), "R5", $sformatf("v%0d all_ready", v),
                all_ready_o, STOP[v] == 0);
            if (STOP[v] != 0) begin
                run = '1;
                #300;
                chk(rst_n_o == '1 && all_ready_o, "R3", $sformatf("v%0d resumed", v),
                    {rst_n_o, all_ready_o}, 5'h1F);
            end
        end

        // Consumer index: the consumer alone stopped holds only the top bit (vector with mask 8)
        chk(HALF[NSRC] == 2, "R8", "consumer is top index", HALF[NSRC], 2);

        // R1: assertion with every clock stopped
        run = '0;
        #5 arst_n = 1'b0;
        #1;
        chk(rst_n_o == '0, "R1", "assert with no clock", rst_n_o, 0);
        chk(src_ready_o == '0, "R1", "src ready cleared with no clock", src_ready_o, 0);
        chk(all_ready_o == 1'b0, "R1", "all_ready cleared with no clock", all_ready_o, 0);
        run = '1;
        #20.5 arst_n = 1'b1;
        #300;
        chk(all_ready_o == 1'b1, "R5", "ready after restart", all_ready_o, 1);

        // R6: enable passes through out of reset and is forced in reset
        func_en = 4'b1010;
        #1;
        chk(cg_en_o == 4'b1010, "R6", "cg_en follows func_en", cg_en_o, 4'b1010);
        func_en = 4'b0101;
        #1;
        chk(cg_en_o == 4'b0101, "R6", "cg_en follows func_en 2", cg_en_o, 4'b0101);
        arst_n = 1'b0;
        #1;
        chk(cg_en_o == 4'b1111, "R6", "cg_en forced by reset", cg_en_o, 4'b1111);
        func_en = '0;
        #20 arst_n = 1'b1;
        #300;

        // R7: scan mode masks the reset
        scan_mode = 1'b1;
        #1 arst_n = 1'b0;
        #40;
        chk(rst_n_o == '1, "R7", "scan holds local resets", rst_n_o, 4'hF);
        chk(src_ready_o == '1 && all_ready_o, "R7", "scan holds ready",
            {src_ready_o, all_ready_o}, 4'hF);
        arst_n = 1'b1;
        #1 scan_mode = 1'b0;
        #40;
        chk(all_ready_o == 1'b1, "R7", "ready after scan exit", all_ready_o, 1);

        chk(mon_bad == 0, "R5", "all_ready never led a source", mon_bad, 0);
        finish_run();
    end

endmodule